// File: doc/BRIEF.md
# Inter-Packet Gap Deferral Timer

This block decides when a half-duplex Ethernet transmitter may start a frame. After the carrier on the medium drops, it counts bit-time ticks until a programmed inter-packet gap has elapsed. It then raises a transmit-allowed flag. The flag stays up until the medium goes busy again or the local transmitter starts a frame.

The gap is split into two zones. The first zone is the blinder window, which begins at the start of the gap. Carrier seen inside it sends the timer back to waiting for an idle line, and the gap is counted again from zero. Carrier seen after the blinder window has no effect, so a late carrier cannot push the port back indefinitely. Both lengths are 5-bit codes in units of four bit-times. The gap code is clamped so that the gap is never shorter than 12 bit-times. The two codes are sampled only while the port is disabled.

Top module: `ipg_defer_timer`

## Requirements
- R1: While `port_en` is low, and after reset, `tx_allowed` is 0 and the timer returns to waiting for an idle line.
- R2: With a tick on every cycle, `tx_allowed` rises N+1 clock cycles after the cycle in which `carrier` is first seen low, where N = 4 × `gap_code` bit-times. Cycles without `bit_tick` do not advance the count.
- R3: A `gap_code` below 3 gives a gap of 12 bit-times. The code values 0, 1, 2 and 3 therefore all produce the same timing.
- R4: `carrier` high while fewer than 4 × `blind_code` ticks of the gap have elapsed restarts the gap. Counting resumes from zero once `carrier` is low again.
- R5: `carrier` high once at least 4 × `blind_code` ticks of the gap have elapsed is ignored. The gap ends at the same cycle it would have ended without the carrier.
- R6: Once raised, `tx_allowed` stays high while `carrier` and `tx_start` stay low. It drops in the cycle after either of them is high.
- R7: A `tx_start` pulse while the gap is still being counted has no effect on when `tx_allowed` rises.
- R8: `gap_code` and `blind_code` are captured on every clock while `port_en` is low. Changes made while `port_en` is high are ignored until the port is next disabled.
- R9: When a restarting carrier (R4) and the final gap tick fall in the same cycle, the restart wins and `tx_allowed` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | 1 | Port enable; codes are captured while low |
| bit_tick | input | 1 | One-cycle pulse per bit-time |
| carrier | input | 1 | Carrier sense from the medium |
| tx_start | input | 1 | Strobe: local transmitter begins a frame |
| gap_code | input | 5 | Gap length in units of 4 bit-times |
| blind_code | input | 5 | Blinder window length in units of 4 bit-times |
| tx_allowed | output | 1 | High when a frame may be started |

## Verification
Carrier activity and the last tick of the gap can coincide. This matters when the blinder window is as long as the gap or longer. The bench provokes it with gap code 3 and blinder code 5, raising the carrier on exactly the cycle that carries the twelfth tick, and expects a full restart. The same carrier timing with blinder code 2 must instead let the gap end on time. The blinder edge is also probed one tick either side of the window boundary, to confirm that the restart cycle count changes exactly there.

// File: rtl/ipg_defer_pkg.sv
package ipg_defer_pkg;

    // Phase of the deferral timer
    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,   // waiting for the medium to go idle
        ST_GAP  = 2'd1,   // counting the inter-packet gap
        ST_OPEN = 2'd2    // gap elapsed, transmission allowed
    } defer_st_e;

endpackage

// File: rtl/ipg_cfg_hold.sv
module ipg_cfg_hold #(
    parameter int FIELD_W    = 5,
    parameter int STEP       = 4,
    parameter int MIN_GAP    = 12,
    parameter int BLIND_RST  = 16,
    parameter int CNT_W      = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               port_en,
    input  logic [FIELD_W-1:0] gap_code,
    input  logic [FIELD_W-1:0] blind_code,
    output logic [CNT_W-1:0]   gap_bits,
    output logic [CNT_W-1:0]   blind_bits
);

    localparam logic [CNT_W-1:0] STEP_V  = CNT_W'(STEP);
    localparam logic [CNT_W-1:0] MIN_V   = CNT_W'(MIN_GAP);
    localparam logic [CNT_W-1:0] BLIND_V = CNT_W'(BLIND_RST * STEP);

    typedef struct packed {
        logic [CNT_W-1:0] gap;
        logic [CNT_W-1:0] blind;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [CNT_W-1:0] gap_scaled;
    logic [CNT_W-1:0] blind_scaled;

    always_comb begin
        gap_scaled   = CNT_W'(gap_code) * STEP_V;
        blind_scaled = CNT_W'(blind_code) * STEP_V;
        cfg_d        = cfg_q;
        // Codes follow the inputs only while the port is off
        if (!port_en) begin
            cfg_d.gap   = (gap_scaled < MIN_V) ? MIN_V : gap_scaled;
            cfg_d.blind = blind_scaled;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{gap: MIN_V, blind: BLIND_V};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign gap_bits   = cfg_q.gap;
    assign blind_bits = cfg_q.blind;

endmodule

// File: rtl/ipg_gap_fsm.sv
module ipg_gap_fsm
    import ipg_defer_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             port_en,
    input  logic             bit_tick,
    input  logic             carrier,
    input  logic             tx_start,
    input  logic [CNT_W-1:0] gap_bits,
    input  logic [CNT_W-1:0] blind_bits,
    output logic             tx_allowed
);

    typedef struct packed {
        defer_st_e        st;
        logic [CNT_W-1:0] cnt;
    } fsm_t;

    fsm_t s_d, s_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             in_blind;

    always_comb begin
        cnt_inc  = s_q.cnt + CNT_W'(1);
        in_blind = (s_q.cnt < blind_bits);
        s_d      = s_q;
        if (!port_en) begin
            s_d = '{st: ST_HOLD, cnt: '0};
        end else begin
            unique case (s_q.st)
                ST_HOLD: begin
                    s_d.cnt = '0;
                    if (!carrier) s_d.st = ST_GAP;
                end
                ST_GAP: begin
                    // Early zone: activity restarts; late zone: ignored
                    if (carrier && in_blind) begin
                        s_d = '{st: ST_HOLD, cnt: '0};
                    end else if (bit_tick) begin
                        if (cnt_inc >= gap_bits) s_d = '{st: ST_OPEN, cnt: '0};
                        else                     s_d.cnt = cnt_inc;
                    end
                end
                ST_OPEN: begin
                    if (carrier || tx_start) s_d = '{st: ST_HOLD, cnt: '0};
                end
                default: s_d = '{st: ST_HOLD, cnt: '0};
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ST_HOLD, cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_allowed = (s_q.st == ST_OPEN);

endmodule

// File: rtl/ipg_defer_timer.sv
module ipg_defer_timer #(
    parameter int FIELD_W   = 5,
    parameter int STEP      = 4,
    parameter int MIN_GAP   = 12,
    parameter int BLIND_RST = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               port_en,
    input  logic               bit_tick,
    input  logic               carrier,
    input  logic               tx_start,
    input  logic [FIELD_W-1:0] gap_code,
    input  logic [FIELD_W-1:0] blind_code,
    output logic               tx_allowed
);

    localparam int MAX_BITS = ((1 << FIELD_W) - 1) * STEP;
    localparam int CNT_W    = $clog2(MAX_BITS + 1);

    logic [CNT_W-1:0] gap_bits_w;
    logic [CNT_W-1:0] blind_bits_w;

    ipg_cfg_hold #(
        .FIELD_W  (FIELD_W),
        .STEP     (STEP),
        .MIN_GAP  (MIN_GAP),
        .BLIND_RST(BLIND_RST),
        .CNT_W    (CNT_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_en   (port_en),
        .gap_code  (gap_code),
        .blind_code(blind_code),
        .gap_bits  (gap_bits_w),
        .blind_bits(blind_bits_w)
    );

    ipg_gap_fsm #(
        .CNT_W(CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_en   (port_en),
        .bit_tick  (bit_tick),
        .carrier   (carrier),
        .tx_start  (tx_start),
        .gap_bits  (gap_bits_w),
        .blind_bits(blind_bits_w),
        .tx_allowed(tx_allowed)
    );

endmodule

// File: rtl/ipg_defer_chk.sv
module ipg_defer_chk #(
    parameter int CNT_W   = 7,
    parameter int MIN_GAP = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             port_en,
    input logic             bit_tick,
    input logic             carrier,
    input logic             tx_start,
    input logic             tx_allowed,
    input logic [CNT_W-1:0] gap_bits
);

    // R1
    off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> !tx_allowed);

    // R2
    rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_allowed) |-> $past(bit_tick));

    // R3
    gap_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gap_bits >= CNT_W'(MIN_GAP));

    // R6
    open_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en && tx_allowed && !carrier && !tx_start) |=> tx_allowed);

    // R6
    open_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_allowed && (carrier || tx_start)) |=> !tx_allowed);

    // R8
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en && $past(port_en)) |-> $stable(gap_bits));

endmodule

bind ipg_defer_timer ipg_defer_chk #(
    .CNT_W  (CNT_W),
    .MIN_GAP(MIN_GAP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .port_en   (port_en),
    .bit_tick  (bit_tick),
    .carrier   (carrier),
    .tx_start  (tx_start),
    .tx_allowed(tx_allowed),
    .gap_bits  (gap_bits_w)
);

// File: tb/tb_ipg_defer_timer.sv
`timescale 1ns/1ps
module tb_ipg_defer_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_en = 1'b0;
    logic       bit_tick = 1'b0;
    logic       carrier = 1'b1;
    logic       tx_start = 1'b0;
    logic [4:0] gap_code = 5'd3;
    logic [4:0] blind_code = 5'd1;
    logic       tx_allowed;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ipg_defer_timer dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_en   (port_en),
        .bit_tick  (bit_tick),
        .carrier   (carrier),
        .tx_start  (tx_start),
        .gap_code  (gap_code),
        .blind_code(blind_code),
        .tx_allowed(tx_allowed)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive one cycle's inputs right after a falling edge, return at the next falling edge
    task automatic cyc(input logic c, input logic t, input logic s);
        carrier  = c;
        bit_tick = t;
        tx_start = s;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Disable, load codes, enable with a busy line
    task automatic prep(input logic [4:0] g, input logic [4:0] b);
        port_en    = 1'b0;
        gap_code   = g;
        blind_code = b;
        cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b1, 1'b0, 1'b0);
        port_en = 1'b1;
        cyc(1'b1, 1'b0, 1'b0);
    endtask

    // Tick every cycle with the line idle except for an optional pulse;
    // returns the cycle count until tx_allowed is seen, or 0
    task automatic run_gap(input int p_at, input int p_len, input bit p_tx,
                           input int limit, output int edges);
        edges = 0;
        for (int i = 0; i < limit; i++) begin
            bit pul;
            pul = (i >= p_at) && (i < p_at + p_len);
            cyc(p_tx ? 1'b0 : pul, 1'b1, p_tx ? pul : 1'b0);
            if (tx_allowed) begin
                edges = i + 1;
                break;
            end
        end
    endtask

    task automatic t_reset();
        chk("R1 reset value", int'(tx_allowed), 0);
        rst_n = 1'b1;
        cyc(1'b0, 1'b1, 1'b0);
        cyc(1'b0, 1'b1, 1'b0);
        chk("R1 disabled after reset", int'(tx_allowed), 0);
    endtask

    task automatic t_lengths();
        int e;
        prep(5'd3, 5'd1);  run_gap(999, 0, 0, 300, e); chk("R2 gap code 3", e, 13);
        prep(5'd10, 5'd1); run_gap(999, 0, 0, 300, e); chk("R2 gap code 10", e, 41);
        prep(5'd31, 5'd1); run_gap(999, 0, 0, 300, e); chk("R2 gap code 31", e, 125);
    endtask

    task automatic t_clamp();
        int e;
        prep(5'd0, 5'd1); run_gap(999, 0, 0, 300, e); chk("R3 gap code 0", e, 13);
        prep(5'd1, 5'd1); run_gap(999, 0, 0, 300, e); chk("R3 gap code 1", e, 13);
        prep(5'd2, 5'd0); run_gap(999, 0, 0, 300, e); chk("R3 gap code 2", e, 13);
    endtask

    task automatic t_blind_restart();
        int e;
        prep(5'd10, 5'd4); run_gap(6, 1, 0, 300, e);  chk("R4 early carrier", e, 48);
        prep(5'd10, 5'd4); run_gap(16, 1, 0, 300, e); chk("R4 last blind tick", e, 58);
    endtask

    task automatic t_blind_ignore();
        int e;
        prep(5'd10, 5'd4); run_gap(17, 1, 0, 300, e); chk("R5 first open tick", e, 41);
        prep(5'd10, 5'd4); run_gap(21, 3, 0, 300, e); chk("R5 late carrier", e, 41);
    endtask

    task automatic t_same_cycle();
        int e;
        prep(5'd3, 5'd5); run_gap(12, 1, 0, 300, e); chk("R9 restart wins", e, 26);
        prep(5'd3, 5'd2); run_gap(12, 1, 0, 300, e); chk("R9 outside blind", e, 13);
    endtask

    task automatic t_open_hold();
        int e;
        int held;
        prep(5'd3, 5'd1); run_gap(999, 0, 0, 300, e);
        held = 1;
        for (int i = 0; i < 10; i++) begin
            cyc(1'b0, 1'b1, 1'b0);
            if (!tx_allowed) held = 0;
        end
        chk("R6 stays open", held, 1);
        cyc(1'b0, 1'b0, 1'b1);
        chk("R6 tx_start closes", int'(tx_allowed), 0);
        run_gap(999, 0, 0, 300, e); chk("R6 reopens after start", e, 13);
        cyc(1'b1, 1'b0, 1'b0);
        chk("R6 carrier closes", int'(tx_allowed), 0);
    endtask

    task automatic t_tx_in_gap();
        int e;
        prep(5'd3, 5'd1); run_gap(5, 2, 1, 300, e); chk("R7 start during gap", e, 13);
    endtask

    task automatic t_tick_gate();
        int e;
        int seen;
        prep(5'd3, 5'd1);
        seen = 0;
        for (int i = 0; i < 30; i++) begin
            cyc(1'b0, 1'b0, 1'b0);
            if (tx_allowed) seen = 1;
        end
        chk("R2 no ticks no progress", seen, 0);
        run_gap(999, 0, 0, 300, e); chk("R2 ticks resume", e, 12);
    endtask

    task automatic t_frozen();
        int e;
        prep(5'd3, 5'd1);
        gap_code = 5'd20;
        cyc(1'b1, 1'b0, 1'b0);
        run_gap(999, 0, 0, 300, e); chk("R8 gap write while on", e, 13);
        prep(5'd20, 5'd1); run_gap(999, 0, 0, 300, e); chk("R8 gap after disable", e, 81);
        prep(5'd10, 5'd4);
        blind_code = 5'd31;
        cyc(1'b1, 1'b0, 1'b0);
        run_gap(21, 1, 0, 300, e); chk("R8 blind write while on", e, 41);
    endtask

    task automatic t_disable();
        int e;
        prep(5'd3, 5'd1); run_gap(999, 0, 0, 300, e);
        port_en = 1'b0;
        cyc(1'b0, 1'b1, 1'b0);
        chk("R1 disable closes", int'(tx_allowed), 0);
    endtask

    initial begin
        #(8 * 50000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b1, 1'b0, 1'b0);
        t_reset();
        t_lengths();
        t_clamp();
        t_blind_restart();
        t_blind_ignore();
        t_same_cycle();
        t_open_hold();
        t_tx_in_gap();
        t_tick_gate();
        t_frozen();
        t_disable();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule